// File: doc/BRIEF.md
# Separable Two-Pass Image Filter

This block smooths an 8-bit raster pixel stream with an N×N kernel that factors into one row filter and one column filter. The row pass runs a short FIR along each image line. Its output goes through a power-of-two normaliser and into N−1 row-length line stores. The column pass then runs the same FIR down each column. The result is normalised again, clamped to the pixel range and sent out with a valid strobe. N is 5 by default.

The same N signed coefficients serve both passes. A 5×5 kernel is therefore described by only 5 stored values, and each output pixel costs 2N multiplies instead of N². Coefficients are loaded one at a time through a simple write strobe. The block is meant for low-pass, Gaussian-like kernels. Only windows that lie wholly inside the frame produce output: there is no edge padding and no frame store.

The stream advances only on accepted pixels, so gaps in the input valid change timing but never results. Line and row positions are tracked inside the block. Every frame is `LINE_W` pixels wide and `FRAME_H` lines tall.

Top module: `sep_fir2d`

## Requirements
- R1: A synchronous active-high reset does four things: it drops `out_vld`, sets `pix_out` to 0, clears the pixel taps and the line and row position, and loads the coefficients with the centre tap (index N/2) equal to 2^`NORM_SH` and all others 0. The first pixel accepted after reset is line 0, column 0, even if reset arrived mid-frame, and pixels presented while reset is high are dropped.
- R2: With the reset coefficients, each output pixel equals the input pixel two lines up and two columns left of the pixel that completed its window (an N/2 offset in both directions).
- R3: For the pixel accepted at line r, column c, the row result is H(r,c) = floor(Σk coef[k]·P(r,c−k) / 2^NORM_SH). The output is floor(Σk coef[k]·H(r−k,c) / 2^NORM_SH), for k from 0 to N−1, with coefficients taken as signed two's-complement.
- R4: Before output, the column result is clamped: negative values give 0 and values above 255 give 255.
- R5: `out_vld` is raised only for pixels accepted at column ≥ N−1 and line ≥ N−1 of the current frame, which gives (LINE_W−N+1)·(FRAME_H−N+1) outputs per frame. The line count wraps after FRAME_H lines, so every frame refills its first N−1 lines before it outputs anything.
- R6: The output for an accepted pixel appears exactly 3 clock cycles after the edge that accepts it. Idle cycles between pixels change neither values nor the order of outputs.
- R7: A clock edge with `coef_we` high and `coef_sel` below N loads `coef_val` into that tap. A `coef_sel` of N or above leaves every tap unchanged.
- R8: When no output is valid, `pix_out` keeps the last output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | $clog2(TAPS) | Tap index to write |
| coef_val | input | COEF_W | Signed tap value |
| pix_in | input | PIX_W | Input pixel, raster order |
| pix_vld | input | 1 | Input pixel valid |
| pix_out | output | PIX_W | Filtered pixel |
| out_vld | output | 1 | Output pixel valid |

## Verification
A fault in the row window or the row normaliser corrupts the first output that uses it, 3 cycles after the pixel that completes the window. A wrong entry in a line store goes unseen until the column pass reads that column again, up to N−1 lines later, and then gives a wrong value at exactly that column. A slipped column or line counter shows up within the same frame as an early, late or missing `out_vld`, or as a per-frame output count that differs from (LINE_W−N+1)·(FRAME_H−N+1). The bench therefore compares every output value and its arrival cycle against an independent model and counts outputs per frame.

// File: rtl/sep_fir_pkg.sv
package sep_fir_pkg;

    // Position flags that travel with each accepted pixel through the pipe.
    typedef struct packed {
        logic vld;     // an accepted pixel occupies this stage
        logic win_ok;  // full N x N window lies inside the frame
    } stage_tag_t;

    localparam stage_tag_t TAG_IDLE = '{vld: 1'b0, win_ok: 1'b0};

    // Clamp a signed value into the unsigned range of 'bits' bits.
    function automatic logic [31:0] clamp_unsigned(input logic signed [63:0] v,
                                                   input int unsigned bits);
        logic signed [63:0] top;
        top = (64'sd1 <<< bits) - 64'sd1;
        if (v < 64'sd0)
            return 32'd0;
        else if (v > top)
            return top[31:0];
        else
            return v[31:0];
    endfunction

endpackage

// File: rtl/sep_fir_raster.sv
module sep_fir_raster
    import sep_fir_pkg::*;
#(
    parameter int TAPS    = 5,
    parameter int LINE_W  = 64,
    parameter int FRAME_H = 48,
    localparam int COL_W  = (LINE_W  > 1) ? $clog2(LINE_W)  : 1,
    localparam int ROW_W  = (FRAME_H > 1) ? $clog2(FRAME_H) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output stage_tag_t       tag_now,
    output logic [COL_W-1:0] col_now
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_W - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(FRAME_H - 1);
    localparam logic [COL_W-1:0] MIN_COL  = COL_W'(TAPS - 1);
    localparam logic [ROW_W-1:0] MIN_ROW  = ROW_W'(TAPS - 1);

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
        end else if (adv) begin
            if (col_q == LAST_COL) begin
                col_q <= '0;
                row_q <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    always_comb begin
        tag_now.vld    = adv;
        tag_now.win_ok = (col_q >= MIN_COL) && (row_q >= MIN_ROW);
        col_now        = col_q;
    end

endmodule

// File: rtl/sep_fir_coef.sv
module sep_fir_coef #(
    parameter int TAPS    = 5,
    parameter int COEF_W  = 8,
    parameter int NORM_SH = 4,
    localparam int SEL_W  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [SEL_W-1:0]             sel,
    input  logic [COEF_W-1:0]            val,
    output logic [TAPS-1:0][COEF_W-1:0]  coef_q
);

    localparam int CENTER = TAPS / 2;
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << NORM_SH;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam logic [COEF_W-1:0] INIT = (k == CENTER) ? UNITY : '0;
        always_ff @(posedge clk) begin
            if (rst)
                coef_q[k] <= INIT;
            else if (we && (sel == SEL_W'(k)))
                coef_q[k] <= val;
        end
    end

endmodule

// File: rtl/sep_fir_hpass.sv
module sep_fir_hpass #(
    parameter int TAPS    = 5,
    parameter int PIX_W   = 8,
    parameter int COEF_W  = 8,
    parameter int NORM_SH = 4,
    parameter int SUM_W   = PIX_W + 1 + COEF_W + $clog2(TAPS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         shift_en,
    input  logic [PIX_W-1:0]             pix,
    input  logic                         calc_en,
    input  logic [TAPS-1:0][COEF_W-1:0]  coef,
    output logic signed [SUM_W-1:0]      h_q
);

    localparam int PROD_W = PIX_W + 1 + COEF_W;

    // win_q[k] holds the pixel k columns left of the newest one
    logic [TAPS-1:0][PIX_W-1:0]  win_q;
    logic signed [PROD_W-1:0]    prod [TAPS];
    logic signed [SUM_W-1:0]     acc;

    always_ff @(posedge clk) begin
        if (rst)
            win_q[0] <= '0;
        else if (shift_en)
            win_q[0] <= pix;
    end

    for (genvar k = 1; k < TAPS; k++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst)
                win_q[k] <= '0;
            else if (shift_en)
                win_q[k] <= win_q[k-1];
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        assign prod[k] = $signed({1'b0, win_q[k]}) * $signed(coef[k]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++)
            acc = acc + SUM_W'(prod[k]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            h_q <= '0;
        else if (calc_en)
            h_q <= acc >>> NORM_SH;
    end

endmodule

// File: rtl/sep_fir_vpass.sv
module sep_fir_vpass
    import sep_fir_pkg::*;
#(
    parameter int TAPS    = 5,
    parameter int PIX_W   = 8,
    parameter int COEF_W  = 8,
    parameter int NORM_SH = 4,
    parameter int LINE_W  = 64,
    parameter int H_W     = PIX_W + 1 + COEF_W + $clog2(TAPS),
    localparam int COL_W  = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    input  logic                         emit,
    input  logic [COL_W-1:0]             col,
    input  logic signed [H_W-1:0]        h_in,
    input  logic [TAPS-1:0][COEF_W-1:0]  coef,
    output logic [PIX_W-1:0]             pix_out,
    output logic                         out_vld
);

    localparam int PROD_W = H_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(TAPS);

    // col_v[k]: row-pass result k lines above the current one, same column
    logic [H_W-1:0]            col_v [TAPS];
    logic signed [PROD_W-1:0]  prod  [TAPS];
    logic signed [ACC_W-1:0]   acc;
    logic signed [ACC_W-1:0]   scaled;

    assign col_v[0] = h_in;

    for (genvar j = 0; j < TAPS - 1; j++) begin : g_line
        logic [H_W-1:0] store [LINE_W];
        assign col_v[j+1] = store[col];
        always_ff @(posedge clk) begin
            if (step)
                store[col] <= col_v[j];
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        assign prod[k] = $signed(col_v[k]) * $signed(coef[k]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++)
            acc = acc + ACC_W'(prod[k]);
        scaled = acc >>> NORM_SH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= step && emit;
            if (step && emit)
                pix_out <= PIX_W'(clamp_unsigned(64'(scaled), PIX_W));
        end
    end

endmodule

// File: rtl/sep_fir2d.sv
module sep_fir2d
    import sep_fir_pkg::*;
#(
    parameter int TAPS    = 5,
    parameter int PIX_W   = 8,
    parameter int COEF_W  = 8,
    parameter int NORM_SH = 4,
    parameter int LINE_W  = 64,
    parameter int FRAME_H = 48,
    localparam int SEL_W  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              coef_we,
    input  logic [SEL_W-1:0]  coef_sel,
    input  logic [COEF_W-1:0] coef_val,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              pix_vld,
    output logic [PIX_W-1:0]  pix_out,
    output logic              out_vld
);

    localparam int COL_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam int H_W   = PIX_W + 1 + COEF_W + $clog2(TAPS);

    logic [TAPS-1:0][COEF_W-1:0] coef_q;
    stage_tag_t                  tag_in, a_tag, b_tag;
    logic [COL_W-1:0]            col_in, a_col, b_col;
    logic signed [H_W-1:0]       h_val;

    sep_fir_coef #(
        .TAPS(TAPS), .COEF_W(COEF_W), .NORM_SH(NORM_SH)
    ) i_coef (
        .clk(clk), .rst(rst), .we(coef_we), .sel(coef_sel),
        .val(coef_val), .coef_q(coef_q)
    );

    sep_fir_raster #(
        .TAPS(TAPS), .LINE_W(LINE_W), .FRAME_H(FRAME_H)
    ) i_raster (
        .clk(clk), .rst(rst), .adv(pix_vld),
        .tag_now(tag_in), .col_now(col_in)
    );

    // Tag and column travel alongside the two arithmetic stages.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_tag <= TAG_IDLE;
            b_tag <= TAG_IDLE;
            a_col <= '0;
            b_col <= '0;
        end else begin
            a_tag <= tag_in;
            b_tag <= a_tag;
            a_col <= col_in;
            b_col <= a_col;
        end
    end

    sep_fir_hpass #(
        .TAPS(TAPS), .PIX_W(PIX_W), .COEF_W(COEF_W),
        .NORM_SH(NORM_SH), .SUM_W(H_W)
    ) i_hpass (
        .clk(clk), .rst(rst), .shift_en(pix_vld), .pix(pix_in),
        .calc_en(a_tag.vld), .coef(coef_q), .h_q(h_val)
    );

    sep_fir_vpass #(
        .TAPS(TAPS), .PIX_W(PIX_W), .COEF_W(COEF_W),
        .NORM_SH(NORM_SH), .LINE_W(LINE_W), .H_W(H_W)
    ) i_vpass (
        .clk(clk), .rst(rst), .step(b_tag.vld), .emit(b_tag.win_ok),
        .col(b_col), .h_in(h_val), .coef(coef_q),
        .pix_out(pix_out), .out_vld(out_vld)
    );

endmodule

// File: rtl/sep_fir2d_chk.sv
module sep_fir2d_chk #(
    parameter int TAPS    = 5,
    parameter int PIX_W   = 8,
    parameter int COEF_W  = 8,
    parameter int LINE_W  = 64,
    localparam int SEL_W  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        pix_vld,
    input logic                        coef_we,
    input logic [SEL_W-1:0]            coef_sel,
    input logic [TAPS-1:0][COEF_W-1:0] coef_q,
    input logic [PIX_W-1:0]            pix_out,
    input logic                        out_vld
);

    localparam logic [31:0] WARM = 32'((TAPS - 1) * LINE_W + TAPS);

    logic [31:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= '0;
        else if (pix_vld && (seen_q < WARM))
            seen_q <= seen_q + 32'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_vld && (pix_out == '0)));                        // R1

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(pix_vld, 3));                                // R6

    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (seen_q >= WARM));                                 // R5

    AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (coef_we && (32'(coef_sel) >= TAPS)) |=> $stable(coef_q));     // R7

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pix_vld, 3)) |-> $stable(pix_out));     // R8

endmodule

bind sep_fir2d sep_fir2d_chk #(
    .TAPS(TAPS), .PIX_W(PIX_W), .COEF_W(COEF_W), .LINE_W(LINE_W)
) i_chk (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .coef_we(coef_we),
    .coef_sel(coef_sel), .coef_q(coef_q), .pix_out(pix_out),
    .out_vld(out_vld)
);

// File: tb/test_sep_fir2d.sv
module test_sep_fir2d;

    localparam int TAPS = 5;
    localparam int NSH  = 4;
    localparam int W    = 16;
    localparam int FH   = 10;
    localparam int MID  = TAPS / 2;
    localparam int PER_FRAME = (W - TAPS + 1) * (FH - TAPS + 1);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coef_we = 1'b0;
    logic [2:0] coef_sel = '0;
    logic [7:0] coef_val = '0;
    logic [7:0] pix_in = '0;
    logic       pix_vld = 1'b0;
    logic [7:0] pix_out;
    logic       out_vld;

    always #2 clk = ~clk;

    sep_fir2d #(
        .TAPS(TAPS), .PIX_W(8), .COEF_W(8), .NORM_SH(NSH),
        .LINE_W(W), .FRAME_H(FH)
    ) i_sep_fir2d (
        .clk(clk), .rst(rst), .coef_we(coef_we), .coef_sel(coef_sel),
        .coef_val(coef_val), .pix_in(pix_in), .pix_vld(pix_vld),
        .pix_out(pix_out), .out_vld(out_vld)
    );

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    out_seen = 0;
    int    last_out = 0;
    int    sat_hi = 0;
    int    sat_lo = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    int mc [TAPS];
    int img [FH][W];
    int hv  [FH][W];
    int mr = 0;
    int mcol = 0;
    int exp_v [$];
    int exp_d [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    // Output monitor: every valid output is matched against the model queue.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_vld) begin
                out_seen++;
                last_out = int'(pix_out);
                if (pix_out == 8'd255) sat_hi++;
                if (pix_out == 8'd0)   sat_lo++;
                if (exp_v.size() == 0) begin
                    check({cur_req, " R5 unexpected out_vld"}, 1, 0);
                end else begin
                    check({cur_req, " pixel value"}, int'(pix_out), exp_v.pop_front());
                    check("R6 output cycle", cyc, exp_d.pop_front());
                end
            end else if (exp_d.size() > 0 && exp_d[0] < cyc) begin
                check({cur_req, " R5 missing output"}, 0, 1);
                void'(exp_v.pop_front());
                void'(exp_d.pop_front());
            end
        end
    end

    function automatic void model_reset();
        mr = 0;
        mcol = 0;
        for (int k = 0; k < TAPS; k++) mc[k] = 0;
        mc[MID] = 1 << NSH;
        exp_v.delete();
        exp_d.delete();
    endfunction

    function automatic void model_step(input int p);
        int acc;
        img[mr][mcol] = p;
        if (mcol >= TAPS - 1) begin
            acc = 0;
            for (int k = 0; k < TAPS; k++) acc += mc[k] * img[mr][mcol-k];
            hv[mr][mcol] = acc >>> NSH;
        end
        if (mr >= TAPS - 1 && mcol >= TAPS - 1) begin
            acc = 0;
            for (int k = 0; k < TAPS; k++) acc += mc[k] * hv[mr-k][mcol];
            acc = acc >>> NSH;
            if (acc < 0)   acc = 0;
            if (acc > 255) acc = 255;
            exp_v.push_back(acc);
            exp_d.push_back(cyc + 3);
        end
        mcol++;
        if (mcol == W) begin
            mcol = 0;
            mr = (mr == FH - 1) ? 0 : mr + 1;
        end
    endfunction

    function automatic int pattern(input int kind, input int seed, input int r, input int c);
        if (kind == 1) return ((r + c) % 2 == 1) ? 255 : 0;
        return (r * 37 + c * 91 + seed * 53 + r * c * 13) & 255;
    endfunction

    task automatic hold(input int n);
        repeat (n) begin
            @(negedge clk);
            pix_vld = 1'b0;
        end
    endtask

    task automatic put_pix(input int p);
        @(negedge clk);
        pix_in  = 8'(p);
        pix_vld = 1'b1;
        model_step(p);
    endtask

    task automatic send_frame(input int kind, input int seed, input bit gaps, input bit drain);
        for (int r = 0; r < FH; r++) begin
            for (int c = 0; c < W; c++) begin
                if (gaps && ((r * W + c) % 3 == 1)) hold(1 + (c % 2));
                put_pix(pattern(kind, seed, r, c));
            end
        end
        if (drain) hold(6);
    endtask

    task automatic write_coef(input int sel, input int val);
        @(negedge clk);
        coef_we  = 1'b1;
        coef_sel = 3'(sel);
        coef_val = 8'(val);
        if (sel < TAPS) mc[sel] = val;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic load_kernel(input int k0, input int k1, input int k2, input int k3, input int k4);
        write_coef(0, k0);
        write_coef(1, k1);
        write_coef(2, k2);
        write_coef(3, k3);
        write_coef(4, k4);
    endtask

    task automatic t_reset();
        cur_req = "R1";
        @(negedge clk);
        rst = 1'b1;
        pix_vld = 1'b1;
        pix_in = 8'hA5;
        repeat (3) @(negedge clk);
        check("R1 out_vld during reset", int'(out_vld), 0);
        check("R1 pix_out during reset", int'(pix_out), 0);
        rst = 1'b0;
        pix_vld = 1'b0;
        model_reset();
        repeat (4) @(negedge clk);
        check("R1 out_vld after reset", int'(out_vld), 0);
        check("R1 pix_out after reset", int'(pix_out), 0);
    endtask

    task automatic t_pass();
        int base;
        cur_req = "R2";
        base = out_seen;
        send_frame(0, 1, 1'b0, 1'b1);
        check("R5 outputs in pass-through frame", out_seen - base, PER_FRAME);
        check("R2 pending outputs", exp_v.size(), 0);
    endtask

    task automatic t_gauss();
        cur_req = "R3";
        load_kernel(1, 4, 6, 4, 1);
        send_frame(0, 2, 1'b0, 1'b1);
        check("R3 pending after smoothing frame", exp_v.size(), 0);
    endtask

    task automatic t_sharp();
        cur_req = "R3";
        load_kernel(0, -8, 32, -8, 0);
        send_frame(0, 3, 1'b0, 1'b1);
        check("R3 pending after signed-tap frame", exp_v.size(), 0);
    endtask

    task automatic t_sat();
        int hi0;
        int lo0;
        cur_req = "R4";
        load_kernel(0, -16, 48, -16, 0);
        hi0 = sat_hi;
        lo0 = sat_lo;
        send_frame(1, 0, 1'b0, 1'b1);
        check("R4 clamp to 255 seen", int'(sat_hi > hi0), 1);
        check("R4 clamp to 0 seen", int'(sat_lo > lo0), 1);
    endtask

    task automatic t_gaps();
        int base;
        cur_req = "R6";
        load_kernel(1, 4, 6, 4, 1);
        base = out_seen;
        send_frame(0, 4, 1'b1, 1'b1);
        check("R6 outputs in gapped frame", out_seen - base, PER_FRAME);
    endtask

    task automatic t_frames();
        int base;
        cur_req = "R5";
        base = out_seen;
        send_frame(0, 5, 1'b0, 1'b0);
        send_frame(0, 6, 1'b0, 1'b1);
        check("R5 outputs over two back-to-back frames", out_seen - base, 2 * PER_FRAME);
    endtask

    task automatic t_badsel();
        cur_req = "R7";
        write_coef(5, 99);
        write_coef(6, -99);
        write_coef(7, 77);
        send_frame(0, 7, 1'b0, 1'b1);
        check("R7 pending after out-of-range writes", exp_v.size(), 0);
    endtask

    task automatic t_hold();
        cur_req = "R8";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 pix_out held while idle", int'(pix_out), last_out);
        end
    endtask

    task automatic t_midreset();
        int base;
        cur_req = "R1";
        for (int i = 0; i < 70; i++) put_pix(pattern(0, 9, i / W, i % W));
        hold(5);
        @(negedge clk);
        rst = 1'b1;
        pix_vld = 1'b1;
        pix_in = 8'h3C;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pix_vld = 1'b0;
        model_reset();
        base = out_seen;
        send_frame(0, 8, 1'b0, 1'b1);
        check("R1 outputs in frame after mid-frame reset", out_seen - base, PER_FRAME);
        check("R1 pending after mid-frame reset", exp_v.size(), 0);
    endtask

    initial begin
        model_reset();
        t_reset();
        t_pass();
        t_gauss();
        t_sharp();
        t_sat();
        t_gaps();
        t_frames();
        t_badsel();
        t_hold();
        t_midreset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule